// File: doc/BRIEF.md
# Socket status change interrupt unit

This block holds the per-socket status and change-interrupt logic of a removable-card socket controller. A host reaches its registers through a byte-wide pair of ports. A write to the index port selects a register, and accesses to the data port then read or write that register. Each socket samples its card-detect, write-protect, ready, power-good and battery-voltage pins through a two-flop synchroniser. The sampled values appear in a status register.

Edges on the card-detect pins and entries into the battery warning and battery dead states are latched into a change register. A read of that register clears it. When an enabled change bit is set, the socket drives one host interrupt line, chosen by a 4-bit line number held in the change-interrupt configuration register. The power-control and general-control registers drive the card power, output-enable, programming-voltage select, I/O-mode and card-reset outputs.

Top module: `sock_stat_irq`

## Requirements
- R1: A write with `host_port`=0 loads `host_wdata` into the index register. A read with `host_port`=0 returns the index register. Data-port accesses (`host_port`=1) act on the register that the index selects.
- R2: The index is decoded as follows. Bit 7 must equal the parameter `CTRL_SEL`, bit 6 selects the socket, and bits 5:0 are the register offset. A data access whose bit 7 does not match, or whose socket is not fitted, writes nothing and reads 0x00.
- R3: Offset 0x00 reads 0x80 OR `REV`, which is upper nibble 8 and a non-zero revision. Writes to offset 0x00 have no effect.
- R4: Offset 0x01 reads the synchronised pins. Bit 6 is power-good, bit 5 is ready, bit 4 is write-protect, bits 3:2 are card-detect and bits 1:0 are battery-voltage; bit 7 reads 0. A pin change is visible in this register no later than three clocks after it occurs.
- R5: Any change, in either direction, on either card-detect pin of a socket sets bit 3 of its change register (offset 0x04).
- R6: Battery-voltage pins going from any other value to 01 set change bit 1 (warning). Battery-voltage bit 0 falling from 1 to 0 sets change bit 0 (dead).
- R7: A data-port read of offset 0x04 returns the change bits and then clears them. An event that arrives in the same cycle as that read stays set afterwards. Writes to offset 0x04 have no effect.
- R8: At offset 0x05, bits 7:4 hold the interrupt line number. `host_irq[n]` is high while that socket has a change bit set at a position whose enable (bit 3, 1 or 0 of offset 0x05) is also set. Line 0 is never driven, and the requests of different sockets are ORed together.
- R9: A change bit whose enable is clear does not raise an interrupt. If its enable is later set while the bit is still pending, the interrupt rises.
- R10: Offset 0x02 reads back the value written to it. Bit 7 drives `card_out_en`, bit 4 drives `card_pwr_en` and bits 1:0 drive `card_vpp` (1 = 5 V, 2 = 12 V, 0 = off).
- R11: Offset 0x03 reads back the value written to it. `card_reset` is high while bit 6 is 0, and `card_io_mode` follows bit 5.
- R12: After reset, every register reads 0x00 (except the identification register), `card_reset` is high, power and output enables are low and no `host_irq` line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| cd_pin | input | 2*NUM_SOCK | Card-detect pins, two per socket |
| wp_pin | input | NUM_SOCK | Write-protect pin per socket |
| rdy_pin | input | NUM_SOCK | Ready pin per socket |
| pgood_pin | input | NUM_SOCK | Card power-good pin per socket |
| bvd_pin | input | 2*NUM_SOCK | Battery-voltage pins, two per socket |
| host_irq | output | 16 | Host interrupt lines |
| card_reset | output | NUM_SOCK | Card reset, active high |
| card_pwr_en | output | NUM_SOCK | Card supply enable |
| card_out_en | output | NUM_SOCK | Card output enable |
| card_vpp | output | 2*NUM_SOCK | Programming-voltage select per socket |
| card_io_mode | output | NUM_SOCK | Socket set to I/O-card mode |

## Verification
The bound checker watches several properties on every cycle:
- index loading and the value of the identification register;
- zero data on a missed decode;
- the clear-on-read of the change register when no event coincides with the read;
- that a latched event is never dropped;
- that a write releasing card reset takes effect;
- that no interrupt line rises without a pending change bit, and that line 0 stays low.

The exact layout of the status bits, the battery warning and dead encodings, and the level behaviour of the interrupt when its enable is set late can only be shown by the bench's directed scenarios. The same holds for a card-detect edge that lands on the very cycle of a change-register read.

// File: rtl/sock_pkg.sv
package sock_pkg;
  localparam int DATA_W    = 8;
  localparam int OFF_W     = 6;
  localparam int IRQ_NUM_W = 4;
  localparam int IRQ_LINES = 1 << IRQ_NUM_W;

  localparam logic [OFF_W-1:0] OFF_ID   = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT = 6'h01;
  localparam logic [OFF_W-1:0] OFF_PWR  = 6'h02;
  localparam logic [OFF_W-1:0] OFF_GCTL = 6'h03;
  localparam logic [OFF_W-1:0] OFF_CHG  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_CCFG = 6'h05;

  localparam int CHG_CD    = 3;
  localparam int CHG_BWARN = 1;
  localparam int CHG_BDEAD = 0;
  localparam logic [DATA_W-1:0] CHG_MASK = 8'b0000_1011;

  typedef struct packed {
    logic       pgood;
    logic       rdy;
    logic       wp;
    logic [1:0] cd;
    logic [1:0] bvd;
  } pins_t;
endpackage

// File: rtl/sock_sync.sv
module sock_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/sock_host_if.sv
module sock_host_if
  import sock_pkg::*;
#(
  parameter int NUM_SOCK = 2,
  parameter bit CTRL_SEL = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic                host_port,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   idx_q,
  output logic [NUM_SOCK-1:0] sock_sel,
  output logic [NUM_SOCK-1:0] sock_wr,
  output logic [NUM_SOCK-1:0] sock_rd,
  output logic [OFF_W-1:0]    reg_off
);
  logic idx_we;
  logic hit;

  // next-state: index load enable and decode
  always_comb begin
    idx_we = host_wr && !host_port;
    hit    = (idx_q[7] == CTRL_SEL) && (int'(idx_q[6]) < NUM_SOCK);
    for (int s = 0; s < NUM_SOCK; s++) begin
      sock_sel[s] = hit && (int'(idx_q[6]) == s);
      sock_wr[s]  = sock_sel[s] && host_wr && host_port;
      sock_rd[s]  = sock_sel[s] && host_rd && host_port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= host_wdata;
  end

  assign reg_off = idx_q[OFF_W-1:0];
endmodule

// File: rtl/sock_regs.sv
module sock_regs
  import sock_pkg::*;
#(
  parameter logic [3:0] REV = 4'h1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [OFF_W-1:0]     off,
  input  logic [DATA_W-1:0]    wdata,
  input  pins_t                pins,
  output logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    chg,
  output logic [DATA_W-1:0]    evt,
  output logic [IRQ_NUM_W-1:0] irq_num,
  output logic                 irq_pend,
  output logic                 card_reset,
  output logic                 pwr_en,
  output logic                 out_en,
  output logic [1:0]           vpp,
  output logic                 io_mode
);
  logic [DATA_W-1:0] pwr_q, gctl_q, ccfg_q, chg_q, chg_d;
  logic [1:0]        cd_prev_q, bvd_prev_q;
  logic              pwr_we, gctl_we, ccfg_we, chg_clr;
  logic              cd_evt, warn_evt, dead_evt;

  // next-state logic
  always_comb begin
    pwr_we   = wr_en && (off == OFF_PWR);
    gctl_we  = wr_en && (off == OFF_GCTL);
    ccfg_we  = wr_en && (off == OFF_CCFG);
    chg_clr  = rd_en && (off == OFF_CHG);

    cd_evt   = |(pins.cd ^ cd_prev_q);
    warn_evt = (pins.bvd == 2'b01) && (bvd_prev_q != 2'b01);
    dead_evt = !pins.bvd[0] && bvd_prev_q[0];

    evt            = '0;
    evt[CHG_CD]    = cd_evt;
    evt[CHG_BWARN] = warn_evt;
    evt[CHG_BDEAD] = dead_evt;

    chg_d = (chg_clr ? '0 : chg_q) | evt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q      <= '0;
      gctl_q     <= '0;
      ccfg_q     <= '0;
      chg_q      <= '0;
      cd_prev_q  <= '0;
      bvd_prev_q <= '0;
    end else begin
      if (pwr_we)  pwr_q  <= wdata;
      if (gctl_we) gctl_q <= wdata;
      if (ccfg_we) ccfg_q <= wdata;
      chg_q      <= chg_d;
      cd_prev_q  <= pins.cd;
      bvd_prev_q <= pins.bvd;
    end
  end

  // read mux
  always_comb begin
    case (off)
      OFF_ID:   rdata = {4'h8, REV};
      OFF_STAT: rdata = {1'b0, pins.pgood, pins.rdy, pins.wp, pins.cd, pins.bvd};
      OFF_PWR:  rdata = pwr_q;
      OFF_GCTL: rdata = gctl_q;
      OFF_CHG:  rdata = chg_q;
      OFF_CCFG: rdata = ccfg_q;
      default:  rdata = '0;
    endcase
  end

  assign chg        = chg_q;
  assign irq_num    = ccfg_q[7:4];
  assign irq_pend   = |(chg_q[3:0] & ccfg_q[3:0] & CHG_MASK[3:0]);
  assign card_reset = !gctl_q[6];
  assign io_mode    = gctl_q[5];
  assign out_en     = pwr_q[7];
  assign pwr_en     = pwr_q[4];
  assign vpp        = pwr_q[1:0];
endmodule

// File: rtl/sock_stat_irq.sv
module sock_stat_irq
  import sock_pkg::*;
#(
  parameter int         NUM_SOCK = 2,
  parameter bit         CTRL_SEL = 1'b0,
  parameter logic [3:0] REV      = 4'h1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic                  host_port,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata,
  input  logic [2*NUM_SOCK-1:0] cd_pin,
  input  logic [NUM_SOCK-1:0]   wp_pin,
  input  logic [NUM_SOCK-1:0]   rdy_pin,
  input  logic [NUM_SOCK-1:0]   pgood_pin,
  input  logic [2*NUM_SOCK-1:0] bvd_pin,
  output logic [15:0]           host_irq,
  output logic [NUM_SOCK-1:0]   card_reset,
  output logic [NUM_SOCK-1:0]   card_pwr_en,
  output logic [NUM_SOCK-1:0]   card_out_en,
  output logic [2*NUM_SOCK-1:0] card_vpp,
  output logic [NUM_SOCK-1:0]   card_io_mode
);
  localparam int PIN_W = $bits(pins_t);

  logic [DATA_W-1:0]        idx_q;
  logic [NUM_SOCK-1:0]      sock_sel, sock_wr, sock_rd, irq_pend;
  logic [OFF_W-1:0]         reg_off;
  logic [DATA_W-1:0]        sock_rdata [NUM_SOCK];
  logic [IRQ_NUM_W-1:0]     irq_num    [NUM_SOCK];
  logic [NUM_SOCK*DATA_W-1:0] chg_all, evt_all;

  sock_host_if #(.NUM_SOCK(NUM_SOCK), .CTRL_SEL(CTRL_SEL)) u_host (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_port(host_port), .host_wdata(host_wdata), .idx_q(idx_q),
    .sock_sel(sock_sel), .sock_wr(sock_wr), .sock_rd(sock_rd), .reg_off(reg_off)
  );

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    logic [PIN_W-1:0] raw, synced;
    assign raw = {pgood_pin[s], rdy_pin[s], wp_pin[s], cd_pin[2*s +: 2], bvd_pin[2*s +: 2]};

    sock_sync #(.W(PIN_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    sock_regs #(.REV(REV)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(sock_wr[s]), .rd_en(sock_rd[s]),
      .off(reg_off), .wdata(host_wdata), .pins(pins_t'(synced)),
      .rdata(sock_rdata[s]), .chg(chg_all[s*DATA_W +: DATA_W]),
      .evt(evt_all[s*DATA_W +: DATA_W]), .irq_num(irq_num[s]),
      .irq_pend(irq_pend[s]), .card_reset(card_reset[s]),
      .pwr_en(card_pwr_en[s]), .out_en(card_out_en[s]),
      .vpp(card_vpp[2*s +: 2]), .io_mode(card_io_mode[s])
    );
  end

  always_comb begin
    host_rdata = '0;
    if (!host_port) begin
      host_rdata = idx_q;
    end else begin
      for (int s = 0; s < NUM_SOCK; s++)
        if (sock_sel[s]) host_rdata = sock_rdata[s];
    end
  end

  always_comb begin
    host_irq = '0;
    for (int s = 0; s < NUM_SOCK; s++)
      if (irq_pend[s] && (irq_num[s] != '0)) host_irq[irq_num[s]] = 1'b1;
  end
endmodule

// File: rtl/sock_stat_irq_chk.sv
module sock_stat_irq_chk #(
  parameter int NUM_SOCK = 2,
  parameter bit CTRL_SEL = 1'b0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  host_wr,
  input logic                  host_rd,
  input logic                  host_port,
  input logic [7:0]            host_wdata,
  input logic [7:0]            host_rdata,
  input logic [15:0]           host_irq,
  input logic [NUM_SOCK-1:0]   card_reset,
  input logic [7:0]            idx_q,
  input logic [NUM_SOCK*8-1:0] chg_all,
  input logic [NUM_SOCK*8-1:0] evt_all
);
  logic [NUM_SOCK-1:0] chg_rd, gctl_wr;
  logic                id_rd;

  always_comb begin
    id_rd = host_rd && host_port && (idx_q[7] == CTRL_SEL) &&
            (int'(idx_q[6]) < NUM_SOCK) && (idx_q[5:0] == 6'h00);
    for (int s = 0; s < NUM_SOCK; s++) begin
      chg_rd[s]  = host_rd && host_port && (idx_q[7] == CTRL_SEL) &&
                   (int'(idx_q[6]) == s) && (idx_q[5:0] == 6'h04);
      gctl_wr[s] = host_wr && host_port && (idx_q[7] == CTRL_SEL) &&
                   (int'(idx_q[6]) == s) && (idx_q[5:0] == 6'h03);
    end
  end

  // R1
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_port) |=> (idx_q == $past(host_wdata)));

  // R3
  id_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |-> ((host_rdata[7:4] == 4'h8) && (host_rdata[3:0] != 4'h0)));

  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_port && (idx_q[7] != CTRL_SEL)) |-> (host_rdata == 8'h00));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq != 16'h0000) |-> (chg_all != '0));

  // R8
  irq_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_irq[0]);

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    // R7
    chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_rd[s] && (evt_all[s*8 +: 8] == 8'h00)) |=> (chg_all[s*8 +: 8] == 8'h00));

    // R7
    evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_all[s*8 +: 8] != 8'h00) |=>
      ((chg_all[s*8 +: 8] & $past(evt_all[s*8 +: 8])) == $past(evt_all[s*8 +: 8])));

    // R11
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gctl_wr[s] && host_wdata[6]) |=> !card_reset[s]);
  end
endmodule

bind sock_stat_irq sock_stat_irq_chk #(.NUM_SOCK(NUM_SOCK), .CTRL_SEL(CTRL_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .host_irq(host_irq), .card_reset(card_reset), .idx_q(idx_q),
  .chg_all(chg_all), .evt_all(evt_all)
);

// File: tb/sock_stat_irq_test.sv
module sock_stat_irq_test;
  localparam int         CLK_PERIOD = 10;
  localparam int         NS         = 2;
  localparam logic [3:0] REV        = 4'h3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd, host_port;
  logic [7:0]  host_wdata, host_rdata;
  logic [3:0]  cd_pin, bvd_pin, card_vpp;
  logic [1:0]  wp_pin, rdy_pin, pgood_pin;
  logic [15:0] host_irq;
  logic [1:0]  card_reset, card_pwr_en, card_out_en, card_io_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sock_stat_irq #(.NUM_SOCK(NS), .CTRL_SEL(1'b0), .REV(REV)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cd_pin(cd_pin), .wp_pin(wp_pin), .rdy_pin(rdy_pin), .pgood_pin(pgood_pin),
    .bvd_pin(bvd_pin), .host_irq(host_irq), .card_reset(card_reset),
    .card_pwr_en(card_pwr_en), .card_out_en(card_out_en), .card_vpp(card_vpp),
    .card_io_mode(card_io_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    host_port = port; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic port, output logic [7:0] d);
    @(negedge clk);
    host_port = port; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  function automatic logic [7:0] ix(input int s, input logic [5:0] off);
    return {1'b0, s[0], off};
  endfunction

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    bus_wr(1'b0, idx);
    bus_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    bus_wr(1'b0, idx);
    bus_rd(1'b1, d);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R12 card_reset", 32'(card_reset), 32'h3);
    check("R12 pwr_en", 32'(card_pwr_en), 32'h0);
    check("R12 out_en", 32'(card_out_en), 32'h0);
    check("R12 host_irq", 32'(host_irq), 32'h0);
    for (int off = 2; off <= 5; off++) begin
      reg_rd(ix(0, 6'(off)), d);
      check("R12 reg", 32'(d), 32'h0);
    end
  endtask

  task automatic t_index();
    logic [7:0] d;
    bus_wr(1'b0, 8'h03);
    bus_rd(1'b0, d);
    check("R1 index readback", 32'(d), 32'h03);
  endtask

  task automatic t_id();
    logic [7:0] d;
    reg_rd(ix(0, 6'h00), d);
    check("R3 id", 32'(d), 32'(8'h80 | 8'(REV)));
    reg_wr(ix(0, 6'h00), 8'h55);
    reg_rd(ix(0, 6'h00), d);
    check("R3 id after write", 32'(d), 32'(8'h80 | 8'(REV)));
  endtask

  task automatic t_power();
    logic [7:0] d;
    reg_wr(ix(0, 6'h02), 8'h92);
    check("R10 out_en", 32'(card_out_en), 32'h1);
    check("R10 pwr_en", 32'(card_pwr_en), 32'h1);
    check("R10 vpp", 32'(card_vpp), 32'h2);
    reg_rd(ix(0, 6'h02), d);
    check("R10 readback", 32'(d), 32'h92);
    reg_wr(ix(0, 6'h02), 8'h00);
    check("R10 off", 32'(card_pwr_en), 32'h0);
  endtask

  task automatic t_gctl();
    logic [7:0] d;
    reg_wr(ix(0, 6'h03), 8'h60);
    check("R11 reset released", 32'(card_reset), 32'h2);
    check("R11 io mode", 32'(card_io_mode), 32'h1);
    reg_rd(ix(0, 6'h03), d);
    check("R11 readback", 32'(d), 32'h60);
    reg_wr(ix(0, 6'h03), 8'h00);
    check("R11 reset again", 32'(card_reset), 32'h3);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    reg_wr(8'h83, 8'h40);
    check("R2 other controller write", 32'(card_reset), 32'h3);
    bus_rd(1'b1, d);
    check("R2 other controller read", 32'(d), 32'h0);
    reg_wr(ix(1, 6'h03), 8'h40);
    check("R2 socket 1 select", 32'(card_reset), 32'h1);
    reg_wr(ix(1, 6'h03), 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(negedge clk);
    cd_pin[1:0] = 2'b11; wp_pin[0] = 1'b1; rdy_pin[0] = 1'b0;
    pgood_pin[0] = 1'b1; bvd_pin[1:0] = 2'b11;
    settle();
    reg_rd(ix(0, 6'h01), d);
    check("R4 status", 32'(d), 32'h5F);
    reg_rd(ix(0, 6'h04), d);
    check("R5 card insert", 32'(d), 32'h08);
    reg_rd(ix(0, 6'h04), d);
    check("R7 cleared", 32'(d), 32'h00);
    @(negedge clk); cd_pin[0] = 1'b0;
    settle();
    reg_rd(ix(0, 6'h04), d);
    check("R5 one pin", 32'(d), 32'h08);
    @(negedge clk); cd_pin[0] = 1'b1;
    settle();
    reg_rd(ix(0, 6'h04), d);
  endtask

  task automatic t_battery();
    logic [7:0] d;
    @(negedge clk); bvd_pin[1:0] = 2'b01;
    settle();
    reg_rd(ix(0, 6'h04), d);
    check("R6 warning", 32'(d), 32'h02);
    @(negedge clk); bvd_pin[1:0] = 2'b00;
    settle();
    reg_rd(ix(0, 6'h04), d);
    check("R6 dead", 32'(d), 32'h01);
    @(negedge clk); bvd_pin[1:0] = 2'b11;
    settle();
    reg_rd(ix(0, 6'h04), d);
    check("R6 recovery no event", 32'(d), 32'h00);
    reg_wr(ix(0, 6'h04), 8'h0B);
    reg_rd(ix(0, 6'h04), d);
    check("R7 write ignored", 32'(d), 32'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    reg_wr(ix(0, 6'h05), 8'h58);
    @(negedge clk); cd_pin[0] = 1'b0;
    settle();
    check("R8 line 5", 32'(host_irq), 32'h0020);
    reg_rd(ix(0, 6'h04), d);
    check("R8 clear drops line", 32'(host_irq), 32'h0);
    reg_wr(ix(0, 6'h05), 8'h51);
    @(negedge clk); cd_pin[0] = 1'b1;
    settle();
    check("R9 disabled event", 32'(host_irq), 32'h0);
    reg_wr(ix(0, 6'h05), 8'h58);
    check("R9 late enable", 32'(host_irq), 32'h0020);
    reg_rd(ix(0, 6'h04), d);
    reg_wr(ix(0, 6'h05), 8'h08);
    @(negedge clk); cd_pin[0] = 1'b0;
    settle();
    check("R8 line zero", 32'(host_irq), 32'h0);
    reg_rd(ix(0, 6'h04), d);
    reg_wr(ix(0, 6'h05), 8'h58);
    reg_wr(ix(1, 6'h05), 8'h98);
    @(negedge clk); cd_pin[0] = 1'b1; cd_pin[2] = 1'b1;
    settle();
    check("R8 two sockets", 32'(host_irq), 32'h0220);
    reg_rd(ix(0, 6'h04), d);
    reg_rd(ix(1, 6'h04), d);
    check("R8 both cleared", 32'(host_irq), 32'h0);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    @(negedge clk); bvd_pin[1:0] = 2'b10;
    settle();
    bus_wr(1'b0, ix(0, 6'h04));
    cd_pin[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    host_port = 1'b1; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
    check("R7 read value", 32'(d), 32'h01);
    bus_rd(1'b1, d);
    check("R7 coincident event kept", 32'(d), 32'h08);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_port = 1'b0; host_wdata = '0;
    cd_pin = '0; bvd_pin = '0; wp_pin = '0; rdy_pin = '0; pgood_pin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_id();
    t_power();
    t_gctl();
    t_decode();
    t_status();
    t_battery();
    t_irq();
    t_coincide();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule